// File: doc/BRIEF.md
# Non-volatile Commit and Recall Sequencer

This block sits between a two-wire serial register engine and the storage that keeps the potentiometer setting across power cycles. When the engine receives a data byte aimed at a non-volatile slot, the sequencer latches its slot index and value. It keeps them pending until the bus shows what comes next. Only a STOP that directly follows that byte's acknowledge turns the pending byte into a programming cycle. That cycle lasts a fixed number of system-clock ticks. Busy is held high for its whole length, and the serial engine uses busy to ignore the master. A START, any further data bit, or the write-protect pin going low while the byte is pending discards it.

The block also owns the wiper register. The wiper comes out of reset at midscale. On the first clock with the supply-good input high, the wiper takes the value stored in slot 0, the initial-value slot. If supply-good drops, the wiper returns to midscale and the recall repeats once the supply is good again. The register map writes the wiper directly through a load strobe. A write to the initial-value slot therefore uses both paths in the same cycle: the wiper load and the non-volatile request.

Top module: `nv_commit_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer resets: `wiper` becomes 0x80 (midscale, 1 << (DW-1)), `busy` and `recall_done` become 0, slot 0 of the store becomes 0x80, and every other slot becomes 0x00.
- R2: While `supply_ok` is low, each edge sets `wiper` to midscale and `recall_done` to 0. On the first edge with `supply_ok` high and `recall_done` low, `wiper` takes the value of slot 0 and `recall_done` becomes 1.
- R3: With `supply_ok` high, `wip_we` loads `wip_wd` into `wiper` on the next edge. When this falls on the same edge as a recall, the loaded value wins and `recall_done` still becomes 1.
- R4: `nv_ack` equals `nv_req & wp_n & ~busy` combinationally. A request seen with `wp_n` low is not latched, so a following STOP starts no cycle and the slot keeps its value.
- R5: If a byte is pending and a cycle has `bus_stop` high with `wp_n` high and neither `bus_start` nor `bus_bit` high, `busy` rises on the next edge. It then stays high for exactly CYC_TICKS cycles.
- R6: A pending byte is discarded, and no cycle starts, if `bus_start`, `bus_bit` or a low `wp_n` is seen in any cycle before the arming STOP. This includes the STOP cycle itself.
- R7: Once `busy` is high, changes on `wp_n` have no effect, and the pending byte is still committed.
- R8: On the edge where `busy` falls, the pending byte is written to slot `nv_addr`, which was captured with the request. The store holds it for later reads.
- R9: While `busy` is high, `nv_ack` is 0 and requests are not latched. A later STOP then starts no cycle.
- R10: `rd_data` shows the content of slot `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply is good enough to read the store |
| wp_n | input | 1 | Write protect, low blocks non-volatile writes |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_bit | input | 1 | One-cycle pulse: a data bit was clocked |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| nv_req | input | 1 | One-cycle pulse: non-volatile data byte received |
| nv_addr | input | AW | Slot index of the requested byte |
| nv_data | input | DW | Value of the requested byte |
| nv_ack | output | 1 | Acknowledge decision for the request |
| wip_we | input | 1 | Wiper load strobe from the register map |
| wip_wd | input | DW | Wiper load value |
| rd_addr | input | AW | Store read index |
| rd_data | output | DW | Store read value |
| wiper | output | DW | Current wiper position |
| busy | output | 1 | Programming cycle in progress |
| recall_done | output | 1 | Power-up recall has completed |

## Verification
Two collisions matter. In the first, `wp_n` falls in the same cycle that `bus_stop` arrives for a pending byte: the protect must win and `busy` must stay low. In the second, `supply_ok` returns high in the same cycle as a `wip_we` load: the load must win over the recall while `recall_done` still sets. The bench provokes both on purpose. A behavioural reference model is compared with the outputs every clock, and directed checks read the affected slot back through `rd_data` to prove nothing was stored.

// File: rtl/nvseq_pkg.sv
// Package: shared constants for the commit and recall sequencer.
// Assumes slot 0 of the store is the initial-value slot used by recall.
package nvseq_pkg;
    localparam int IVR_SLOT = 0;

    // Midscale code for a wiper of the given width.
    function automatic int midscale(input int dw);
        return 1 << (dw - 1);
    endfunction
endpackage

// File: rtl/nvseq_pending.sv
// Module: holds one non-volatile byte between its ACK and the bus event that follows.
// Assumes bus event pulses are one cycle wide and that the byte's ACK cycle is the nv_req cycle.
module nvseq_pending #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          wp_n,
    input  logic          bus_start,
    input  logic          bus_bit,
    input  logic          bus_stop,
    input  logic          nv_req,
    input  logic [AW-1:0] nv_addr,
    input  logic [DW-1:0] nv_data,
    output logic          nv_ack,
    output logic          go,
    output logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_data
);
    logic pend;
    logic cancel;

    // Acknowledge decision: protected or busy requests get no ACK.
    always_comb nv_ack = nv_req && wp_n && !busy;

    // Any bus activity or a protect drop before the STOP discards the byte.
    always_comb cancel = !wp_n || bus_start || bus_bit;

    // Arm a programming cycle only on a clean STOP right after the byte.
    always_comb go = pend && !busy && !cancel && bus_stop;

    // Pending flag and captured slot and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            p_addr <= '0;
            p_data <= '0;
        end else if (!busy) begin
            if (pend) begin
                if (cancel || bus_stop) pend <= 1'b0;
            end else if (nv_ack) begin
                pend   <= 1'b1;
                p_addr <= nv_addr;
                p_data <= nv_data;
            end
        end
    end
endmodule

// File: rtl/nvseq_timer.sv
// Module: counts a programming cycle of CYC_TICKS clocks and flags its last cycle.
// Assumes go is not raised while busy; the caller gates it.
module nvseq_timer #(
    parameter int CYC_TICKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(CYC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC_TICKS - 1);

    logic [CW-1:0] left;

    // Last busy cycle: the store is written on this edge.
    always_comb commit = busy && (left == '0);

    // Busy flag and remaining-tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (commit) begin
            busy <= 1'b0;
        end else if (busy) begin
            left <= left - 1'b1;
        end else if (go) begin
            busy <= 1'b1;
            left <= LAST;
        end
    end
endmodule

// File: rtl/nvseq_store.sv
// Module: register-array stand-in for the non-volatile slots, with factory defaults on reset.
// Assumes one write per cycle; read ports are combinational.
module nvseq_store #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ivr
);
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] MID = DW'(nvseq_pkg::midscale(DW));

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [DW-1:0] DEF = (i == nvseq_pkg::IVR_SLOT) ? MID : '0;
        // One slot: factory value on reset, committed byte on write.
        always_ff @(posedge clk) begin
            if (!rst_n)                        mem[i] <= DEF;
            else if (we && waddr == AW'(i))    mem[i] <= wdata;
        end
    end

    // Read ports: general read and the initial-value slot for recall.
    always_comb begin
        rdata = mem[raddr];
        ivr   = mem[nvseq_pkg::IVR_SLOT];
    end
endmodule

// File: rtl/nvseq_wiper.sv
// Module: wiper register with midscale preset, recall from the initial-value slot and direct loads.
// Assumes supply_ok is synchronous to clk.
module nvseq_wiper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic [DW-1:0] ivr,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] wiper,
    output logic          recall_done
);
    localparam logic [DW-1:0] MID = DW'(nvseq_pkg::midscale(DW));

    // Wiper position: midscale without supply, recall once, loads take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            wiper       <= MID;
            recall_done <= 1'b0;
        end else begin
            if (we)                wiper <= wd;
            else if (!recall_done) wiper <= ivr;
            recall_done <= 1'b1;
        end
    end
endmodule

// File: rtl/nv_commit_seq.sv
// Module: top of the commit and recall sequencer.
// Assumes the serial engine decodes bus events into one-cycle pulses and NoACKs the master while busy.
module nv_commit_seq #(
    parameter int AW        = 3,
    parameter int DW        = 8,
    parameter int CYC_TICKS = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          wp_n,
    input  logic          bus_start,
    input  logic          bus_bit,
    input  logic          bus_stop,
    input  logic          nv_req,
    input  logic [AW-1:0] nv_addr,
    input  logic [DW-1:0] nv_data,
    output logic          nv_ack,
    input  logic          wip_we,
    input  logic [DW-1:0] wip_wd,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] wiper,
    output logic          busy,
    output logic          recall_done
);
    logic          go;
    logic          commit;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;
    logic [DW-1:0] ivr;

    nvseq_pending #(.AW(AW), .DW(DW)) pend_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wp_n(wp_n),
        .bus_start(bus_start), .bus_bit(bus_bit), .bus_stop(bus_stop),
        .nv_req(nv_req), .nv_addr(nv_addr), .nv_data(nv_data),
        .nv_ack(nv_ack), .go(go), .p_addr(p_addr), .p_data(p_data)
    );

    nvseq_timer #(.CYC_TICKS(CYC_TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .commit(commit)
    );

    nvseq_store #(.AW(AW), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(p_addr), .wdata(p_data),
        .raddr(rd_addr), .rdata(rd_data), .ivr(ivr)
    );

    nvseq_wiper #(.DW(DW)) wiper_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ivr(ivr),
        .we(wip_we), .wd(wip_wd), .wiper(wiper), .recall_done(recall_done)
    );
endmodule

// File: rtl/nv_commit_seq_chk.sv
// Module: property checker bound to nv_commit_seq.
// Assumes the synchronous active-low reset of the design.
module nv_commit_seq_chk #(
    parameter int AW        = 3,
    parameter int DW        = 8,
    parameter int CYC_TICKS = 500000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          wp_n,
    input logic          bus_stop,
    input logic          nv_req,
    input logic          nv_ack,
    input logic          wip_we,
    input logic [DW-1:0] wip_wd,
    input logic [DW-1:0] wiper,
    input logic          busy,
    input logic          recall_done
);
    localparam logic [DW-1:0] MID = DW'(nvseq_pkg::midscale(DW));

    logic [31:0] run;

    // Length of the current busy stretch, counted in the checker.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run <= '0;
        else                 run <= run + 1'b1;
    end

    assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop && wp_n));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run) == 32'(CYC_TICKS - 1)));

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < 32'(CYC_TICKS)));

    assert_no_ack_protected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && !wp_n) |-> !nv_ack);

    assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nv_ack);

    assert_midscale_no_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (wiper == MID && !recall_done));

    assert_recall_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_done) |-> $past(supply_ok));

    assert_wiper_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wip_we && supply_ok)) |-> (wiper == $past(wip_wd)));
endmodule

bind nv_commit_seq nv_commit_seq_chk #(.AW(AW), .DW(DW), .CYC_TICKS(CYC_TICKS)) chk_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_n(wp_n),
    .bus_stop(bus_stop), .nv_req(nv_req), .nv_ack(nv_ack),
    .wip_we(wip_we), .wip_wd(wip_wd), .wiper(wiper), .busy(busy),
    .recall_done(recall_done)
);

// File: tb/nv_commit_seq_tb_top.sv
module nv_commit_seq_tb_top;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int CYC = 6;

    logic          clk = 1'b0;
    logic          rst_n, supply_ok, wp_n;
    logic          bus_start, bus_bit, bus_stop, nv_req, wip_we;
    logic [AW-1:0] nv_addr, rd_addr;
    logic [DW-1:0] nv_data, wip_wd;
    logic          nv_ack, busy, recall_done;
    logic [DW-1:0] rd_data, wiper;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nv_commit_seq #(.AW(AW), .DW(DW), .CYC_TICKS(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_n(wp_n),
        .bus_start(bus_start), .bus_bit(bus_bit), .bus_stop(bus_stop),
        .nv_req(nv_req), .nv_addr(nv_addr), .nv_data(nv_data), .nv_ack(nv_ack),
        .wip_we(wip_we), .wip_wd(wip_wd), .rd_addr(rd_addr), .rd_data(rd_data),
        .wiper(wiper), .busy(busy), .recall_done(recall_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge.
    int m_arr [8];
    int m_wip, m_done, m_busy, m_left, m_pend, m_pa, m_pd;
    bit m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_arr[i]) m_arr[i] = 0;
            m_arr[0] = 128;
            m_wip = 128; m_done = 0; m_busy = 0; m_left = 0; m_pend = 0;
        end else begin
            if (!supply_ok) begin
                m_wip = 128; m_done = 0;
            end else begin
                if (m_done == 0) m_wip = m_arr[0];
                if (wip_we) m_wip = wip_wd;
                m_done = 1;
            end
            if (m_busy != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_arr[m_pa] = m_pd;
                    m_busy = 0;
                end
            end else if (m_pend != 0) begin
                if (!wp_n || bus_start || bus_bit) m_pend = 0;
                else if (bus_stop) begin
                    m_pend = 0; m_busy = 1; m_left = CYC;
                end
            end else if (nv_req && wp_n) begin
                m_pend = 1; m_pa = nv_addr; m_pd = nv_data;
            end
        end
        m_live = 1;
    end

    // Compare every cycle, away from the clock edges.
    always @(negedge clk) begin
        #3;
        if (m_live) begin
            chk("R3 wiper vs model", wiper, m_wip);
            chk("R2 recall_done vs model", recall_done, m_done);
            chk("R5 busy vs model", busy, m_busy);
            chk("R4 nv_ack vs model", nv_ack, (nv_req && wp_n && m_busy == 0) ? 1 : 0);
            chk("R10 rd_data vs model", rd_data, m_arr[rd_addr]);
        end
    end

    task automatic clr();
        bus_start = 0; bus_bit = 0; bus_stop = 0; nv_req = 0; wip_we = 0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            clr();
        end
    endtask

    task automatic request(input int a, input int d);
        @(negedge clk);
        clr();
        nv_req = 1; nv_addr = AW'(a); nv_data = DW'(d);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R5 watchdog expired act=1 exp=0");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; supply_ok = 0; wp_n = 1; rd_addr = 0;
        nv_addr = 0; nv_data = 0; wip_wd = 0;
        clr();
        wait_cyc(3); #3;
        chk("R1 reset wiper", wiper, 8'h80);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset recall_done", recall_done, 0);
        chk("R1 reset slot0", rd_data, 8'h80);
        @(negedge clk); clr(); rst_n = 1; rd_addr = 3; #3;
        chk("R1 reset slot3", rd_data, 0);

        wait_cyc(2); #3;
        chk("R2 midscale without supply", wiper, 8'h80);
        chk("R2 no recall without supply", recall_done, 0);
        @(negedge clk); supply_ok = 1;
        wait_cyc(1); #3;
        chk("R2 recall done", recall_done, 1);

        @(negedge clk); clr(); wip_we = 1; wip_wd = 8'h33;
        wait_cyc(1); #3;
        chk("R3 volatile load", wiper, 8'h33);

        // Initial-value write: wiper load and non-volatile request together.
        request(0, 8'h5A); wip_we = 1; wip_wd = 8'h5A; #3;
        chk("R4 ack with wp high", nv_ack, 1);
        @(negedge clk); clr(); bus_stop = 1;
        @(negedge clk); clr(); #3;
        chk("R5 busy after stop", busy, 1);
        chk("R3 wiper follows initial write", wiper, 8'h5A);
        request(2, 8'h99); #3;
        chk("R9 no ack while busy", nv_ack, 0);
        @(negedge clk); clr(); bus_stop = 1; wp_n = 0;
        wait_cyc(3); #3;
        chk("R5 busy in last cycle", busy, 1);
        wait_cyc(1); #3;
        chk("R5 busy ends after CYC", busy, 0);
        rd_addr = 0; #1;
        chk("R7 commit despite wp low", rd_data, 8'h5A);
        rd_addr = 2; #1;
        chk("R9 busy request not stored", rd_data, 0);
        wait_cyc(2); #3;
        chk("R9 no cycle from ignored request", busy, 0);

        // Protected request (wp still low).
        request(3, 8'h77); #3;
        chk("R4 no ack with wp low", nv_ack, 0);
        @(negedge clk); clr(); wp_n = 1; bus_stop = 1;
        wait_cyc(1); #3;
        chk("R4 no cycle after protected byte", busy, 0);
        rd_addr = 3; #1;
        chk("R4 protected slot unchanged", rd_data, 0);

        // Cancel by further data bit.
        request(4, 8'h11);
        @(negedge clk); clr(); bus_bit = 1;
        @(negedge clk); clr(); bus_stop = 1;
        wait_cyc(1); #3;
        chk("R6 cancel by data bit", busy, 0);
        // Cancel by repeated START.
        request(4, 8'h12);
        @(negedge clk); clr(); bus_start = 1;
        @(negedge clk); clr(); bus_stop = 1;
        wait_cyc(1); #3;
        chk("R6 cancel by restart", busy, 0);
        // Cancel by protect drop before STOP.
        request(4, 8'h13);
        @(negedge clk); clr(); wp_n = 0;
        @(negedge clk); clr(); wp_n = 1; bus_stop = 1;
        wait_cyc(1); #3;
        chk("R6 cancel by wp drop", busy, 0);
        // Collision: protect drop in the STOP cycle.
        request(4, 8'h14);
        @(negedge clk); clr(); wp_n = 0; bus_stop = 1;
        @(negedge clk); clr(); wp_n = 1; #3;
        chk("R6 wp wins over stop", busy, 0);
        rd_addr = 4; #1;
        chk("R6 cancelled slot unchanged", rd_data, 0);

        // Plain commit to a general slot.
        request(6, 8'hC3);
        @(negedge clk); clr(); bus_stop = 1;
        wait_cyc(CYC + 1); #3;
        chk("R8 busy released", busy, 0);
        rd_addr = 6; #1;
        chk("R8 general slot committed", rd_data, 8'hC3);

        // Supply drop and recall of the stored value.
        @(negedge clk); clr(); supply_ok = 0;
        wait_cyc(1); #3;
        chk("R2 midscale on supply drop", wiper, 8'h80);
        @(negedge clk); supply_ok = 1;
        wait_cyc(1); #3;
        chk("R2 recall stored value", wiper, 8'h5A);
        chk("R2 recall flag", recall_done, 1);

        // Collision: recall and wiper load in one cycle.
        @(negedge clk); clr(); supply_ok = 0;
        @(negedge clk); clr(); supply_ok = 1; wip_we = 1; wip_wd = 8'h21;
        wait_cyc(1); #3;
        chk("R3 load wins over recall", wiper, 8'h21);
        chk("R3 recall flag with load", recall_done, 1);

        wait_cyc(2);
        summary();
        $finish;
    end
endmodule